// File: doc/BRIEF.md
# Nested Stack Frame Setup Sequencer

This block carries out the stack frame setup that a procedure performs on entry in a block-structured language. A single start pulse hands it several inputs: the caller's frame pointer and stack pointer, a 16-bit frame size, an 8-bit nesting level, a stack width (16, 32 or 64 bits) and an operand-size select. The block then works through a fixed series of steps on a byte-addressed memory port. It pushes the old frame pointer. It copies the display, which is the chain of enclosing frame pointers that sits below the old frame. It pushes the new frame pointer value. Last, it reserves the local area by lowering the stack pointer.

The display copy is a loop driven by memory. Each pass steps the frame pointer down by one element, reads the element at that address, waits one cycle for the read data, and pushes the value. The number of passes depends on the nesting level. When the last stack pointer would fall below a programmed lower limit, or would wrap past zero, the block leaves the original pointer values on its outputs and raises a sticky fault flag.

Top module: `frame_setup_seq`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. A start pulse while `busy` is high is ignored: the run in progress finishes with its own operands and results. The memory port is inactive (`mem_req` low) whenever `busy` is low.
- R2: Only the low 5 bits of `nest_level` are used, so the level is taken modulo 32. For example, 33 behaves as 1 and 32 behaves as 0.
- R3: The first memory access is always a write of the old frame pointer. Its size is the stack width: 2, 4 or 8 bytes for `width_mode` 0, 1 or 2, and `width_mode` 3 behaves as 2. It goes to the stack pointer minus that size. The decremented stack pointer is kept as the new frame value.
- R4: With a reduced level of 0, that first write is the only memory access. `fp_out` becomes the new frame value and `sp_out` becomes the new frame value minus `frame_size`.
- R5: With a reduced level L of 2 or more, L−1 copy passes run. Each pass lowers the working frame pointer by one element, reads the element there, and pushes it. A push lowers the stack pointer by one element and then writes at the new stack pointer.
- R6: The element size is 8 bytes in 64-bit width. Otherwise it is 4 bytes when `op32` is 1 and 2 bytes when `op32` is 0.
- R7: With any nonzero reduced level, one element holding the new frame value is pushed after the copy passes. The final `sp_out` is measured from below that push.
- R8: A fault occurs when `frame_size` exceeds the stack pointer at the final step (a wrap), or when the resulting stack pointer is below `stack_limit`. On a fault, `fp_out` and `sp_out` take the values of `fp_in` and `sp_in` sampled at start. `fault` is set together with `done`, stays set while idle, and clears on the next accepted start. `fp_out` and `sp_out` change only together with `done`.
- R9: All pointer arithmetic and all port addresses use only the low 16, 32 or 64 bits selected by the width. `fp_out` and `sp_out` keep the start-time bits above that width.
- R10: Accesses use `mem_size` 1, 2 or 3 for 2, 4 or 8 bytes. Write data sits in the low bytes of `mem_wdata` in little-endian order. Read data is taken from `mem_rdata` in the cycle after the read request, and only its low element bytes are used.
- R11: `busy` is high from the cycle after the accepting edge. `done` is a one-cycle pulse, with `busy` low, that appears after the 2nd clock edge counted from the accepting edge for level 0, and after the 3·L-th edge for reduced level L ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken when idle |
| width_mode | input | 2 | Stack width: 0=16, 1=32, 2 or 3=64 bits |
| op32 | input | 1 | Operand size 32 when set, 16 when clear (ignored in 64-bit width) |
| nest_level | input | 8 | Lexical nesting level, taken modulo 32 |
| frame_size | input | 16 | Bytes of local storage to reserve |
| fp_in | input | 64 | Frame pointer at start |
| sp_in | input | 64 | Stack pointer at start |
| stack_limit | input | 64 | Lowest permitted final stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Sticky stack fault of the last run |
| fp_out | output | 64 | Resulting frame pointer |
| sp_out | output | 64 | Resulting stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_size | output | 2 | Access size code |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data, little-endian in low bytes |
| mem_rdata | input | 64 | Read data, valid the cycle after a read |

## Verification
The completion pulse is due a fixed number of edges after the accepting edge: two for level 0 and three per level otherwise. The bench counts edges from the accepting edge and samples `done` at the falling edge that follows each one, so the measured latency is compared exactly against that count. Pointer results, the fault flag and `busy` are read at the falling edge where `done` is first seen. Memory contents are compared byte by byte against a shadow model once the run has ended. Stickiness and the ignoring of a second start are each checked at a falling edge a set number of cycles after the stimulus.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PUSH_FP  = 3'd1,
    ST_RD       = 3'd2,
    ST_WAIT     = 3'd3,
    ST_COPY     = 3'd4,
    ST_PUSH_TMP = 3'd5,
    ST_FINAL    = 3'd6
  } fsq_state_e;

  localparam logic [1:0] SZ_2B = 2'd1;
  localparam logic [1:0] SZ_4B = 2'd2;
  localparam logic [1:0] SZ_8B = 2'd3;
endpackage

// File: rtl/fsq_width_dec.sv
module fsq_width_dec #(
  parameter int PTR_W = 64
) (
  input  logic [1:0]       width_mode,
  input  logic             op32,
  output logic [PTR_W-1:0] ptr_mask,
  output logic [PTR_W-1:0] el_mask,
  output logic [PTR_W-1:0] sw_mask,
  output logic [3:0]       sw_bytes,
  output logic [3:0]       el_bytes,
  output logic [1:0]       sw_code,
  output logic [1:0]       el_code
);
  import fsq_pkg::*;

  // One mask per byte count; bit i set when i lies below nb*8
  function automatic logic [PTR_W-1:0] byte_mask(input logic [3:0] nb);
    logic [PTR_W-1:0] m;
    for (int i = 0; i < PTR_W; i++) m[i] = (i < int'(nb) * 8);
    return m;
  endfunction

  always_comb begin
    case (width_mode)
      2'd0:    begin sw_bytes = 4'd2; sw_code = SZ_2B; end
      2'd1:    begin sw_bytes = 4'd4; sw_code = SZ_4B; end
      default: begin sw_bytes = 4'd8; sw_code = SZ_8B; end
    endcase
    if (width_mode[1])  begin el_bytes = 4'd8; el_code = SZ_8B; end
    else if (op32)      begin el_bytes = 4'd4; el_code = SZ_4B; end
    else                begin el_bytes = 4'd2; el_code = SZ_2B; end
  end

  assign ptr_mask = byte_mask(sw_bytes);
  assign sw_mask  = byte_mask(sw_bytes);
  assign el_mask  = byte_mask(el_bytes);
endmodule

// File: rtl/fsq_loop_cnt.sv
module fsq_loop_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - 1'b1;
  end

  assign last = (count == CNT_W'(1));
endmodule

// File: rtl/fsq_limit_chk.sv
module fsq_limit_chk #(
  parameter int PTR_W  = 64,
  parameter int SIZE_W = 16
) (
  input  logic [PTR_W-1:0]  sp_cur,
  input  logic [SIZE_W-1:0] frame_size,
  input  logic [PTR_W-1:0]  limit,
  input  logic [PTR_W-1:0]  mask,
  output logic [PTR_W-1:0]  new_sp,
  output logic              fault
);
  logic [PTR_W-1:0] size_ext;
  logic             wraps;

  assign size_ext = PTR_W'(frame_size);
  assign wraps    = (sp_cur & mask) < size_ext;
  assign new_sp   = (sp_cur - size_ext) & mask;
  assign fault    = wraps | (new_sp < (limit & mask));
endmodule

// File: rtl/frame_setup_seq.sv
module frame_setup_seq #(
  parameter int PTR_W    = 64,
  parameter int SIZE_W   = 16,
  parameter int LVL_W    = 8,
  parameter int NEST_MOD = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        width_mode,
  input  logic              op32,
  input  logic [LVL_W-1:0]  nest_level,
  input  logic [SIZE_W-1:0] frame_size,
  input  logic [PTR_W-1:0]  fp_in,
  input  logic [PTR_W-1:0]  sp_in,
  input  logic [PTR_W-1:0]  stack_limit,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [PTR_W-1:0]  fp_out,
  output logic [PTR_W-1:0]  sp_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [PTR_W-1:0]  mem_wdata,
  input  logic [PTR_W-1:0]  mem_rdata
);
  import fsq_pkg::*;

  localparam int LVL_USE = $clog2(NEST_MOD);

  fsq_state_e        state;
  logic [1:0]        mode_q;
  logic              op_q;
  logic [LVL_USE-1:0] lvl_q;
  logic [SIZE_W-1:0] size_q;
  logic [PTR_W-1:0]  lim_q, fp0_q, sp0_q;
  logic [PTR_W-1:0]  fp_w, sp_w, tmp_q, rbuf_q;
  logic              fault_q, done_q;

  logic [PTR_W-1:0]  ptr_mask, el_mask, sw_mask;
  logic [3:0]        sw_bytes, el_bytes;
  logic [1:0]        sw_code, el_code;
  logic [PTR_W-1:0]  sp_dec_sw, sp_dec_el, fp_dec_el;
  logic [PTR_W-1:0]  new_sp;
  logic              lim_fault;
  logic [LVL_USE-1:0] cnt;
  logic              cnt_last;
  logic              accept;
  logic [LVL_USE-1:0] lvl_in;

  assign lvl_in = nest_level[LVL_USE-1:0];
  assign accept = (state == ST_IDLE) && start;

  fsq_width_dec #(.PTR_W(PTR_W)) u_wdec (
    .width_mode (mode_q),
    .op32       (op_q),
    .ptr_mask   (ptr_mask),
    .el_mask    (el_mask),
    .sw_mask    (sw_mask),
    .sw_bytes   (sw_bytes),
    .el_bytes   (el_bytes),
    .sw_code    (sw_code),
    .el_code    (el_code)
  );

  fsq_loop_cnt #(.CNT_W(LVL_USE)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (lvl_in - 1'b1),
    .dec      (state == ST_COPY),
    .count    (cnt),
    .last     (cnt_last)
  );

  fsq_limit_chk #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_lim (
    .sp_cur     (sp_w),
    .frame_size (size_q),
    .limit      (lim_q),
    .mask       (ptr_mask),
    .new_sp     (new_sp),
    .fault      (lim_fault)
  );

  // Pointer steps, all confined to the selected width
  assign sp_dec_sw = (sp_w - PTR_W'(sw_bytes)) & ptr_mask;
  assign sp_dec_el = (sp_w - PTR_W'(el_bytes)) & ptr_mask;
  assign fp_dec_el = (fp_w - PTR_W'(el_bytes)) & ptr_mask;

  // Memory port decoded from the state register
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_size  = el_code;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_PUSH_FP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_size  = sw_code;
        mem_addr  = sp_dec_sw;
        mem_wdata = fp_w & sw_mask;
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = fp_dec_el;
      end
      ST_COPY: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_dec_el;
        mem_wdata = rbuf_q;
      end
      ST_PUSH_TMP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_dec_el;
        mem_wdata = tmp_q & el_mask;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= '0;
      op_q    <= 1'b0;
      lvl_q   <= '0;
      size_q  <= '0;
      lim_q   <= '0;
      fp0_q   <= '0;
      sp0_q   <= '0;
      fp_w    <= '0;
      sp_w    <= '0;
      tmp_q   <= '0;
      rbuf_q  <= '0;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
      fp_out  <= '0;
      sp_out  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          done_q <= 1'b0;
          if (start) begin
            mode_q  <= width_mode;
            op_q    <= op32;
            lvl_q   <= lvl_in;
            size_q  <= frame_size;
            lim_q   <= stack_limit;
            fp0_q   <= fp_in;
            sp0_q   <= sp_in;
            fp_w    <= fp_in;
            sp_w    <= sp_in;
            fault_q <= 1'b0;
            state   <= ST_PUSH_FP;
          end
        end
        ST_PUSH_FP: begin
          sp_w  <= sp_dec_sw;
          tmp_q <= sp_dec_sw;
          fp_w  <= fp_w & ptr_mask;
          if (lvl_q == '0)                 state <= ST_FINAL;
          else if (lvl_q == LVL_USE'(1))   state <= ST_PUSH_TMP;
          else                             state <= ST_RD;
        end
        ST_RD: begin
          fp_w  <= fp_dec_el;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          rbuf_q <= mem_rdata & el_mask;
          state  <= ST_COPY;
        end
        ST_COPY: begin
          sp_w  <= sp_dec_el;
          state <= cnt_last ? ST_PUSH_TMP : ST_RD;
        end
        ST_PUSH_TMP: begin
          sp_w  <= sp_dec_el;
          state <= ST_FINAL;
        end
        ST_FINAL: begin
          if (lim_fault) begin
            fault_q <= 1'b1;
            fp_out  <= fp0_q;
            sp_out  <= sp0_q;
          end else begin
            fp_out <= (fp0_q & ~ptr_mask) | (tmp_q & ptr_mask);
            sp_out <= (sp0_q & ~ptr_mask) | (new_sp & ptr_mask);
          end
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = done_q;
  assign fault = fault_q;
endmodule

// File: rtl/frame_setup_seq_chk.sv
module frame_setup_seq_chk #(
  parameter int PTR_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [PTR_W-1:0] fp_out,
  input logic [PTR_W-1:0] sp_out,
  input logic             mem_req
);
  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  assert_fault_edges_R8: assert property (@(posedge clk) disable iff (rst)
    (fault != $past(fault)) |-> (done || $past(start && !busy)));

  assert_fp_only_done_R8: assert property (@(posedge clk) disable iff (rst)
    (fp_out != $past(fp_out)) |-> done);

  assert_sp_only_done_R8: assert property (@(posedge clk) disable iff (rst)
    (sp_out != $past(sp_out)) |-> done);
endmodule

bind frame_setup_seq frame_setup_seq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .fault   (fault),
  .fp_out  (fp_out),
  .sp_out  (sp_out),
  .mem_req (mem_req)
);

// File: tb/frame_setup_seq_tb.sv
module frame_setup_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  width_mode = '0;
  logic        op32 = 1'b0;
  logic [7:0]  nest_level = '0;
  logic [15:0] frame_size = '0;
  logic [63:0] fp_in = '0, sp_in = '0, stack_limit = '0;
  logic        busy, done, fault, mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [63:0] fp_out, sp_out, mem_addr, mem_wdata;
  logic [63:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] bmem [0:4095];
  logic [7:0] smem [0:4095];

  always #5 clk = ~clk;

  frame_setup_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .width_mode(width_mode), .op32(op32),
    .nest_level(nest_level), .frame_size(frame_size), .fp_in(fp_in),
    .sp_in(sp_in), .stack_limit(stack_limit), .busy(busy), .done(done),
    .fault(fault), .fp_out(fp_out), .sp_out(sp_out), .mem_req(mem_req),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Byte-addressed little-endian memory, read data one cycle after request
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < (2 << (mem_size - 1)); b++)
          bmem[(mem_addr[11:0] + 12'(b))] <= mem_wdata[8*b +: 8];
      end else begin
        for (int b = 0; b < 8; b++)
          mem_rdata[8*b +: 8] <= bmem[(mem_addr[11:0] + 12'(b))];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 4096; i++) begin
      bmem[i] = 8'(i * 7 + 3);
      smem[i] = 8'(i * 7 + 3);
    end
  endtask

  task automatic s_wr(input logic [63:0] a, input logic [63:0] d, input int nb);
    for (int b = 0; b < nb; b++) smem[a[11:0] + 12'(b)] = d[8*b +: 8];
  endtask

  function automatic logic [63:0] s_rd(input logic [63:0] a, input int nb);
    logic [63:0] v = '0;
    for (int b = 0; b < nb; b++) v[8*b +: 8] = smem[a[11:0] + 12'(b)];
    return v;
  endfunction

  // Shadow model built from the requirements
  task automatic model(input logic [1:0] md, input logic op, input logic [7:0] lv,
                       input logic [15:0] sz, input logic [63:0] fp, sp, lim,
                       output logic [63:0] efp, esp, output bit eflt,
                       output int elat);
    logic [63:0] m, s, f, t, ns, v;
    int sw, e, L;
    sw = (md == 2'd0) ? 2 : (md == 2'd1) ? 4 : 8;
    e  = md[1] ? 8 : (op ? 4 : 2);
    m  = (sw == 8) ? '1 : ((64'd1 << (sw * 8)) - 1);
    L  = lv % 32;
    s = (sp - 64'(sw)) & m;
    s_wr(s, fp & m, sw);
    t = s;
    f = fp & m;
    if (L > 0) begin
      for (int i = 1; i < L; i++) begin
        f = (f - 64'(e)) & m;
        v = s_rd(f, e);
        s = (s - 64'(e)) & m;
        s_wr(s, v, e);
      end
      s = (s - 64'(e)) & m;
      s_wr(s, t, e);
    end
    ns   = (s - 64'(sz)) & m;
    eflt = (s < 64'(sz)) || (ns < (lim & m));
    efp  = eflt ? fp : ((fp & ~m) | t);
    esp  = eflt ? sp : ((sp & ~m) | ns);
    elat = (L == 0) ? 2 : 3 * L;
  endtask

  task automatic run_case(input logic [1:0] md, input logic op, input logic [7:0] lv,
                          input logic [15:0] sz, input logic [63:0] fp, sp, lim,
                          input bit glitch, input string tag);
    logic [63:0] efp, esp;
    bit eflt, got;
    int elat, n, bad;
    init_mem();
    model(md, op, lv, sz, fp, sp, lim, efp, esp, eflt, elat);
    @(negedge clk);
    width_mode = md; op32 = op; nest_level = lv; frame_size = sz;
    fp_in = fp; sp_in = sp; stack_limit = lim; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R11 busy after accept"}, 64'(busy), 64'd1);
    chk(fault == 1'b0, {tag, " R8 fault cleared at start"}, 64'(fault), 64'd0);
    if (glitch) begin
      // R1: second start while busy with different operands
      start = 1'b1; nest_level = 8'd5; frame_size = 16'h0077;
      fp_in = 64'h0400; sp_in = 64'h0C00;
    end
    n = 0; got = 0;
    while (!got && n < 400) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (done) got = 1;
    end
    chk(n == elat, {tag, " R11 done latency"}, 64'(n), 64'(elat));
    chk(busy == 1'b0, {tag, " R11 idle with done"}, 64'(busy), 64'd0);
    chk(fp_out == efp, {tag, " R4/R7/R9 fp_out"}, fp_out, efp);
    chk(sp_out == esp, {tag, " R4/R7/R9 sp_out"}, sp_out, esp);
    chk(fault == eflt, {tag, " R8 fault"}, 64'(fault), 64'(eflt));
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 4096; i++) if (bmem[i] !== smem[i]) bad++;
    chk(bad == 0, {tag, " R3/R5/R6/R10 memory image"}, 64'(bad), 64'd0);
  endtask

  // {mode, op32, level, size, fp, sp, limit, high tag}
  localparam logic [90:0] VEC [0:10] = '{
    {2'd2, 1'b1, 8'd0,  16'h0020, 16'h0800, 16'h0F00, 16'h0100, 16'h0000},
    {2'd1, 1'b1, 8'd1,  16'h0010, 16'h0700, 16'h0E00, 16'h0000, 16'h0000},
    {2'd2, 1'b0, 8'd3,  16'h0040, 16'h0800, 16'h0F00, 16'h0100, 16'h0000},
    {2'd1, 1'b0, 8'd4,  16'h0008, 16'h0600, 16'h0E80, 16'h0000, 16'h0000},
    {2'd0, 1'b1, 8'd5,  16'h0030, 16'h0900, 16'h0F80, 16'h0100, 16'hABCD},
    {2'd0, 1'b0, 8'd33, 16'h0004, 16'h0880, 16'h0F40, 16'h0000, 16'h0000},
    {2'd2, 1'b1, 8'd32, 16'h0010, 16'h0800, 16'h0F00, 16'h0000, 16'h0000},
    {2'd3, 1'b1, 8'd2,  16'h0018, 16'h0880, 16'h0F00, 16'h0000, 16'h0000},
    {2'd1, 1'b1, 8'd31, 16'h0100, 16'h0A00, 16'h0FF0, 16'h0000, 16'h1234},
    {2'd2, 1'b1, 8'd2,  16'h0200, 16'h0800, 16'h0F00, 16'h0E00, 16'h0000},
    {2'd0, 1'b1, 8'd0,  16'h0040, 16'h0800, 16'h0010, 16'h0000, 16'h0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // Reset state
    chk(busy == 0 && done == 0, "R11 reset busy/done", {62'd0, busy, done}, 64'd0);
    chk(fault == 0, "R8 reset fault", 64'(fault), 64'd0);
    chk(fp_out == 0 && sp_out == 0, "R8 reset pointers", fp_out | sp_out, 64'd0);
    chk(mem_req == 0, "R1 reset port idle", 64'(mem_req), 64'd0);

    // Vector table: cases 1 through 8 cover R2..R7, R9, R10; 9 and 10 cover R8
    for (int k = 0; k < 11; k++) begin
      logic [90:0] v;
      v = VEC[k];
      run_case(v[90:89], v[88], v[87:80], v[79:64],
               {v[15:0], 32'd0, v[63:48]}, {v[15:0], 32'd0, v[47:32]},
               {48'd0, v[31:16]}, 1'b0, $sformatf("vec%0d", k));
    end

    // R8: fault stays set while idle
    repeat (5) @(negedge clk);
    chk(fault == 1'b1, "R8 fault sticky while idle", 64'(fault), 64'd1);

    // R1: start pulse during a run is ignored
    run_case(2'd2, 1'b0, 8'd3, 16'h0040, 64'h0800, 64'h0F00, 64'h0100, 1'b1,
             "R1 busy-start");

    // R2: level 34 must behave as level 2
    run_case(2'd1, 1'b1, 8'd34, 16'h0020, 64'h0700, 64'h0E00, 64'h0, 1'b0,
             "R2 level 34");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule